// File: doc/BRIEF.md
# MSI Vector Aggregator

This block collects message-signalled interrupts for a PCIe root complex host bridge and merges them into one level interrupt for the host CPU. An endpoint raises vector `v` by writing the 32-bit value `v` to a single four-byte doorbell. The block records that vector in one of two sticky 32-bit status words, 64 vectors in all, and drives `irq` high.

The host sees the block through a small 32-bit register bus with 8-bit byte offsets. It can read two enable words and two status words. It clears serviced vectors by writing ones to the status words. Clearing has two special cases. A zero write does nothing at all. An all-ones write wipes a status word as initialisation and leaves `irq` where it was. Every other clearing write lowers `irq` once both status words are empty.

Doorbell values outside the vector range are dropped and reported with a one-cycle error pulse. Writes narrower than 32 bits are handled the same way. The enable words are storage only: they do not mask status or the interrupt.

Top module: `msi_irq_agg`

## Requirements
- R1: A doorbell write of value v (0..31) sets bit v of status word 0 at offset 0xE8. A value v (32..63) sets bit v-32 of status word 1 at offset 0xEC. Both changes are visible after the next clock edge.
- R2: Every accepted doorbell write drives `irq` to 1 on the next edge, even when its status bit was already set.
- R3: A doorbell write with a value of 64 or more is dropped: no status bit changes and `irq` is not raised. The same holds for a write with any byte strobe low. Either case pulses `db_err` high for exactly the one cycle after the write.
- R4: A host write to a status word clears exactly the bits that are 1 in the written value and leaves the others set.
- R5: A host write of 0x00000000 to a status word changes neither the status words nor `irq`.
- R6: A host write of 0xFFFFFFFF to a status word clears that word and leaves `irq` unchanged, even when both words end up empty.
- R7: After any other nonzero clearing write, `irq` falls to 0 on the next edge if both status words are then empty. Otherwise it stays 1.
- R8: The enable words at offsets 0xE0 (vectors 0..31) and 0xE4 (vectors 32..63) read back what was last written and reset to 0. Their contents never mask status bits or `irq`.
- R9: When a doorbell write and a host clear arrive in the same cycle, the doorbell's bit ends up set and `irq` ends up 1, even if the clear names that bit.
- R10: After reset, all four registers read 0, and `irq` and `db_err` are 0.
- R11: A read request returns its data on `reg_rdata` in the cycle after `reg_rd`. Offsets other than the four registers read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| db_wr | input | 1 | Doorbell write strobe |
| db_strb | input | 4 | Doorbell byte strobes; all four must be set |
| db_data | input | 32 | Doorbell data, the vector number |
| reg_wr | input | 1 | Host register write |
| reg_rd | input | 1 | Host register read |
| reg_addr | input | 8 | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, one cycle after `reg_rd` |
| irq | output | 1 | Level interrupt toward the host |
| db_err | output | 1 | One-cycle pulse for a dropped doorbell write |

## Verification
The bench first drives `irq` high while both status words are empty, using an all-ones initialisation write. It then checks that a later partial clear of bits that are already zero lowers the line. A design that lowered `irq` on the all-ones write would lose that state, and one that checked emptiness only when bits actually changed would leave `irq` stuck high. The bench also fires a doorbell and a clear of the same bit in one cycle. If the clear wins, a vector is lost and `irq` drops. It repeats a vector whose bit is already set, and a design that raised `irq` only on a newly set bit would miss that repeat. Finally it sends out-of-range values and narrow strobes, and confirms that neither leaves a stray status bit or interrupt.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

   localparam int unsigned DEF_NUM_VEC  = 64;
   localparam int unsigned DEF_WORD_W   = 32;
   localparam int unsigned DEF_ADDR_W   = 8;
   localparam int unsigned DEF_EN_BASE  = 'hE0;
   localparam int unsigned DEF_STS_BASE = 'hE8;

   // kind of host write seen on a status word this cycle
   typedef enum logic [1:0] {
      CLR_NONE  = 2'd0,
      CLR_PLAIN = 2'd1,
      CLR_INIT  = 2'd2
   } clr_kind_e;

endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode
   import msi_agg_pkg::*;
#(
   parameter int unsigned NUM_VEC = DEF_NUM_VEC,
   parameter int unsigned WORD_W  = DEF_WORD_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                db_wr,
   input  logic [WORD_W/8-1:0] db_strb,
   input  logic [WORD_W-1:0]   db_data,
   output logic [NUM_VEC-1:0]  set_vec,
   output logic                db_accept,
   output logic                db_err
);

   localparam int unsigned VEC_W = $clog2(NUM_VEC);

   logic full_word;
   logic in_range;
   logic err_q;

   assign full_word = &db_strb;
   assign in_range  = (db_data < WORD_W'(NUM_VEC));
   assign db_accept = db_wr && full_word && in_range;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_onehot
      assign set_vec[v] = db_accept && (db_data[VEC_W-1:0] == VEC_W'(v));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= db_wr && !(full_word && in_range);
   end

   assign db_err = err_q;

endmodule

// File: rtl/msi_status_bank.sv
module msi_status_bank
   import msi_agg_pkg::*;
#(
   parameter int unsigned NUM_WORDS = DEF_NUM_VEC / DEF_WORD_W,
   parameter int unsigned WORD_W    = DEF_WORD_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WORDS*WORD_W-1:0]   set_flat,
   input  logic [NUM_WORDS*WORD_W-1:0]   clr_flat,
   output logic [NUM_WORDS*WORD_W-1:0]   sts_flat,
   output logic                          next_empty
);

   logic [NUM_WORDS-1:0] word_busy;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] sts_q;
      logic [WORD_W-1:0] sts_d;

      // a set in the same cycle overrides a clear of the same bit
      assign sts_d = (sts_q & ~clr_flat[w*WORD_W +: WORD_W])
                   | set_flat[w*WORD_W +: WORD_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sts_q <= '0;
         else        sts_q <= sts_d;
      end

      assign word_busy[w]                = |sts_d;
      assign sts_flat[w*WORD_W +: WORD_W] = sts_q;
   end

   assign next_empty = ~|word_busy;

endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
   import msi_agg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      any_set,
   input  clr_kind_e clr_kind,
   input  logic      next_empty,
   output logic      irq
);

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (any_set) begin
         irq_q <= 1'b1;
      end else if (clr_kind == CLR_PLAIN && next_empty) begin
         irq_q <= 1'b0;
      end
   end

   assign irq = irq_q;

endmodule

// File: rtl/msi_reg_if.sv
module msi_reg_if
   import msi_agg_pkg::*;
#(
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned WORD_W     = DEF_WORD_W,
   parameter int unsigned NUM_WORDS  = DEF_NUM_VEC / DEF_WORD_W,
   parameter int unsigned EN_BASE    = DEF_EN_BASE,
   parameter int unsigned STS_BASE   = DEF_STS_BASE,
   parameter bit          RDATA_FLOP = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic                        reg_rd,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [WORD_W-1:0]           reg_wdata,
   input  logic [NUM_WORDS*WORD_W-1:0] sts_flat,
   output logic [WORD_W-1:0]           reg_rdata,
   output logic [NUM_WORDS*WORD_W-1:0] clr_flat,
   output clr_kind_e                   clr_kind
);

   localparam int unsigned STEP = WORD_W / 8;

   logic [NUM_WORDS-1:0] hit_en;
   logic [NUM_WORDS-1:0] hit_sts;
   logic [NUM_WORDS*WORD_W-1:0] en_flat;
   logic [NUM_WORDS*WORD_W-1:0] rd_terms;
   logic [WORD_W-1:0] rd_mux;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(EN_BASE  + STEP * w);
      localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(STS_BASE + STEP * w);
      logic [WORD_W-1:0] en_q;

      assign hit_en[w]  = (reg_addr == EN_ADDR);
      assign hit_sts[w] = (reg_addr == STS_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  en_q <= '0;
         else if (reg_wr && hit_en[w]) en_q <= reg_wdata;
      end

      assign en_flat[w*WORD_W +: WORD_W]  = en_q;
      assign clr_flat[w*WORD_W +: WORD_W] =
         (reg_wr && hit_sts[w]) ? reg_wdata : '0;
      assign rd_terms[w*WORD_W +: WORD_W] =
         ({WORD_W{hit_en[w]}}  & en_q) |
         ({WORD_W{hit_sts[w]}} & sts_flat[w*WORD_W +: WORD_W]);
   end

   always_comb begin
      rd_mux = '0;
      for (int w = 0; w < int'(NUM_WORDS); w++) begin
         rd_mux = rd_mux | rd_terms[w*WORD_W +: WORD_W];
      end
   end

   always_comb begin
      clr_kind = CLR_NONE;
      if (reg_wr && |hit_sts) begin
         if (reg_wdata == '0)       clr_kind = CLR_NONE;
         else if (&reg_wdata)       clr_kind = CLR_INIT;
         else                       clr_kind = CLR_PLAIN;
      end
   end

   if (RDATA_FLOP) begin : g_rd_flop
      logic [WORD_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rdata_q <= '0;
         else if (reg_rd) rdata_q <= rd_mux;
      end
      assign reg_rdata = rdata_q;
   end else begin : g_rd_comb
      assign reg_rdata = reg_rd ? rd_mux : '0;
   end

endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg
   import msi_agg_pkg::*;
#(
   parameter int unsigned NUM_VEC    = DEF_NUM_VEC,
   parameter int unsigned WORD_W     = DEF_WORD_W,
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned EN_BASE    = DEF_EN_BASE,
   parameter int unsigned STS_BASE   = DEF_STS_BASE,
   parameter bit          RDATA_FLOP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                db_wr,
   input  logic [WORD_W/8-1:0] db_strb,
   input  logic [WORD_W-1:0]   db_data,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [WORD_W-1:0]   reg_wdata,
   output logic [WORD_W-1:0]   reg_rdata,
   output logic                irq,
   output logic                db_err
);

   localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W;
   localparam int unsigned STEP      = WORD_W / 8;
   localparam int unsigned SPAN      = NUM_WORDS * STEP;

   // elaboration-time parameter checks
   if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
      $error("WORD_W must be a nonzero multiple of 8");
   end
   if (NUM_VEC < 2 || NUM_VEC % WORD_W != 0) begin : g_bad_vec
      $error("NUM_VEC must be a multiple of WORD_W and at least 2");
   end
   if (STS_BASE + SPAN > (1 << ADDR_W) || EN_BASE + SPAN > (1 << ADDR_W)) begin : g_bad_map
      $error("register window does not fit the address width");
   end
   if (!(EN_BASE + SPAN <= STS_BASE || STS_BASE + SPAN <= EN_BASE)) begin : g_overlap
      $error("enable and status windows overlap");
   end

   logic [NUM_VEC-1:0] set_vec;
   logic               db_accept;
   logic [NUM_VEC-1:0] clr_flat;
   logic [NUM_VEC-1:0] sts_flat;
   logic               next_empty;
   clr_kind_e          clr_kind;

   msi_db_decode #(
      .NUM_VEC (NUM_VEC),
      .WORD_W  (WORD_W)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .db_wr     (db_wr),
      .db_strb   (db_strb),
      .db_data   (db_data),
      .set_vec   (set_vec),
      .db_accept (db_accept),
      .db_err    (db_err)
   );

   msi_status_bank #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_flat   (set_vec),
      .clr_flat   (clr_flat),
      .sts_flat   (sts_flat),
      .next_empty (next_empty)
   );

   msi_reg_if #(
      .ADDR_W     (ADDR_W),
      .WORD_W     (WORD_W),
      .NUM_WORDS  (NUM_WORDS),
      .EN_BASE    (EN_BASE),
      .STS_BASE   (STS_BASE),
      .RDATA_FLOP (RDATA_FLOP)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .sts_flat  (sts_flat),
      .reg_rdata (reg_rdata),
      .clr_flat  (clr_flat),
      .clr_kind  (clr_kind)
   );

   msi_irq_ctrl u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .any_set    (db_accept),
      .clr_kind   (clr_kind),
      .next_empty (next_empty),
      .irq        (irq)
   );

endmodule

// File: rtl/msi_irq_agg_chk.sv
module msi_irq_agg_chk #(
   parameter int unsigned NUM_VEC  = 64,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned STS_BASE = 'hE8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                db_wr,
   input logic [WORD_W/8-1:0] db_strb,
   input logic [WORD_W-1:0]   db_data,
   input logic                reg_wr,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [WORD_W-1:0]   reg_wdata,
   input logic                irq,
   input logic                db_err,
   input logic [NUM_VEC-1:0]  sts_flat
);

   localparam int unsigned VEC_W = $clog2(NUM_VEC);
   localparam int unsigned SPAN  = (NUM_VEC / WORD_W) * (WORD_W / 8);

   logic good_db;
   logic bad_db;
   logic sts_hit;

   assign good_db = db_wr && (&db_strb) && (db_data < WORD_W'(NUM_VEC));
   assign bad_db  = db_wr && !((&db_strb) && (db_data < WORD_W'(NUM_VEC)));
   assign sts_hit = reg_wr && (int'(reg_addr) >= int'(STS_BASE))
                  && (int'(reg_addr) < int'(STS_BASE + SPAN))
                  && (reg_addr[1:0] == 2'b00);

   // R1: accepted vector shows up in status
   p_vec_recorded_r1: assert property (@(posedge clk) disable iff (!rst_n)
      good_db |=> sts_flat[$past(db_data[VEC_W-1:0])]);

   // R2: accepted vector raises the line
   p_db_raises_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      good_db |=> irq);

   // R3: dropped writes flag an error
   p_bad_db_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bad_db |=> db_err);

   // R3: error is a single-cycle pulse tied to a rejected write
   p_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(db_err) |-> $past(bad_db));

   // R5: zero write is a no-op
   p_zero_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_hit && reg_wdata == '0 && !db_wr) |=> ($stable(sts_flat) && $stable(irq)));

   // R6: all-ones initialisation keeps the line
   p_init_keeps_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_hit && (&reg_wdata) && !db_wr) |=> (irq == $past(irq)));

   // R7: the line only falls after a clearing write that emptied status
   p_fall_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(sts_hit) && sts_flat == '0));

   // R2: the line only rises on an accepted vector
   p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(good_db));

endmodule

bind msi_irq_agg msi_irq_agg_chk #(
   .NUM_VEC  (NUM_VEC),
   .WORD_W   (WORD_W),
   .ADDR_W   (ADDR_W),
   .STS_BASE (STS_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .db_wr     (db_wr),
   .db_strb   (db_strb),
   .db_data   (db_data),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .irq       (irq),
   .db_err    (db_err),
   .sts_flat  (sts_flat)
);

// File: tb/test_msi_irq_agg.sv
`timescale 1ns/1ps
module test_msi_irq_agg;

   localparam logic [7:0] A_EN0  = 8'hE0;
   localparam logic [7:0] A_EN1  = 8'hE4;
   localparam logic [7:0] A_STS0 = 8'hE8;
   localparam logic [7:0] A_STS1 = 8'hEC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        db_wr = 1'b0;
   logic [3:0]  db_strb = 4'h0;
   logic [31:0] db_data = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        db_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model built from the requirements
   logic [31:0] m_sts [2];
   logic [31:0] m_en  [2];
   logic        m_irq;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_d = 1'b0;

   always #2.5 clk = ~clk;

   msi_irq_agg i_msi_irq_agg (
      .clk       (clk),
      .rst_n     (rst_n),
      .db_wr     (db_wr),
      .db_strb   (db_strb),
      .db_data   (db_data),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq),
      .db_err    (db_err)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // monitor: read data appears one cycle after the request (R11)
   always @(posedge clk) rd_d <= reg_rd;
   always @(negedge clk) begin
      if (rd_d) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11: unexpected read data 0x%08h expected none", reg_rdata);
         end else begin
            check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
         end
      end
   end

   function automatic logic [31:0] model_read(logic [7:0] a);
      case (a)
         A_EN0:   return m_en[0];
         A_EN1:   return m_en[1];
         A_STS0:  return m_sts[0];
         A_STS1:  return m_sts[1];
         default: return 32'h0;
      endcase
   endfunction

   // one cycle of stimulus, with the model advanced from the requirements
   task automatic drive(bit dw, logic [31:0] dd, logic [3:0] ds,
                        bit hw, logic [7:0] ha, logic [31:0] hd,
                        string tag, bit exp_err);
      bit acc;
      bit plain;
      @(negedge clk);
      db_wr = dw; db_data = dd; db_strb = ds;
      reg_wr = hw; reg_addr = ha; reg_wdata = hd;
      acc = dw && (ds == 4'hF) && (dd < 64);
      plain = 1'b0;
      if (hw && (ha == A_EN0)) m_en[0] = hd;
      if (hw && (ha == A_EN1)) m_en[1] = hd;
      if (hw && (ha == A_STS0 || ha == A_STS1)) begin
         m_sts[ha == A_STS1] &= ~hd;
         plain = (hd != 32'h0) && (hd != 32'hFFFF_FFFF);
      end
      if (acc) m_sts[dd[5]][dd[4:0]] = 1'b1;
      if (acc) m_irq = 1'b1;
      else if (plain && m_sts[0] == 0 && m_sts[1] == 0) m_irq = 1'b0;
      @(negedge clk);
      db_wr = 1'b0; reg_wr = 1'b0; db_strb = 4'h0;
      check({tag, " irq"}, {31'h0, irq}, {31'h0, m_irq});
      check({tag, " db_err"}, {31'h0, db_err}, {31'h0, exp_err});
   endtask

   task automatic doorbell(logic [31:0] v, logic [3:0] s, string tag, bit exp_err);
      drive(1'b1, v, s, 1'b0, 8'h0, 32'h0, tag, exp_err);
   endtask

   task automatic host_wr(logic [7:0] a, logic [31:0] d, string tag);
      drive(1'b0, 32'h0, 4'h0, 1'b1, a, d, tag, 1'b0);
   endtask

   task automatic host_rd(logic [7:0] a, string tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic read_all(string tag);
      host_rd(A_STS0, {tag, " sts0"});
      host_rd(A_STS1, {tag, " sts1"});
   endtask

   initial begin
      m_sts[0] = '0; m_sts[1] = '0; m_en[0] = '0; m_en[1] = '0; m_irq = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      check("R10 irq", {31'h0, irq}, 32'h0);
      check("R10 db_err", {31'h0, db_err}, 32'h0);
      host_rd(A_EN0, "R10 en0");
      host_rd(A_EN1, "R10 en1");
      read_all("R10");

      // R1 / R2: vectors land in the right word and bit
      doorbell(32'd5, 4'hF, "R1 vec5", 1'b0);
      read_all("R1 after 5");
      doorbell(32'd37, 4'hF, "R1 vec37", 1'b0);
      doorbell(32'd63, 4'hF, "R1 vec63", 1'b0);
      doorbell(32'd0, 4'hF, "R1 vec0", 1'b0);
      doorbell(32'd31, 4'hF, "R1 vec31", 1'b0);
      read_all("R1 mix");

      // R3: out of range and narrow writes dropped
      doorbell(32'd64, 4'hF, "R3 vec64", 1'b1);
      doorbell(32'hFFFF_FFFF, 4'hF, "R3 huge", 1'b1);
      doorbell(32'd2, 4'h3, "R3 narrow", 1'b1);
      read_all("R3 unchanged");

      // R5: zero write does nothing
      host_wr(A_STS0, 32'h0, "R5 zero");
      read_all("R5");

      // R4 / R7: partial clear with bits remaining
      host_wr(A_STS0, 32'h0000_0001, "R4 clr bit0");
      read_all("R4");

      // R6: initialisation clears but keeps irq high with status empty
      host_wr(A_STS0, 32'hFFFF_FFFF, "R6 init0");
      host_wr(A_STS1, 32'hFFFF_FFFF, "R6 init1");
      read_all("R6 empty");
      check("R6 irq held", {31'h0, irq}, 32'h1);

      // R7: later partial clear on empty status drops the line
      host_wr(A_STS1, 32'h0000_0001, "R7 drop");
      check("R7 irq low", {31'h0, irq}, 32'h0);

      // R3: bad doorbell must not raise the line
      doorbell(32'd100, 4'hF, "R3 no irq", 1'b1);

      // R2: repeat of an already set vector still raises
      doorbell(32'd3, 4'hF, "R2 first", 1'b0);
      host_wr(A_STS0, 32'h0000_0010, "R7 keep (bit3 left)");
      doorbell(32'd3, 4'hF, "R2 repeat", 1'b0);
      host_wr(A_STS0, 32'h0000_0008, "R7 empty again");
      doorbell(32'd3, 4'hF, "R2 after drop", 1'b0);
      doorbell(32'd3, 4'hF, "R2 dup set", 1'b0);
      read_all("R2");

      // R9: same-cycle set and clear of the same bit
      drive(1'b1, 32'd3, 4'hF, 1'b1, A_STS0, 32'h0000_0008, "R9 same bit", 1'b0);
      read_all("R9 same");
      drive(1'b1, 32'd40, 4'hF, 1'b1, A_STS0, 32'h0000_0008, "R9 other word", 1'b0);
      read_all("R9 other");

      // R8: enables are plain storage and never mask
      host_wr(A_EN0, 32'hA5A5_0001, "R8 wr en0");
      host_wr(A_EN1, 32'h0000_1234, "R8 wr en1");
      host_rd(A_EN0, "R8 en0");
      host_rd(A_EN1, "R8 en1");
      host_wr(A_EN0, 32'h0, "R8 en0 zero");
      host_wr(A_STS1, 32'hFFFF_FFFF, "R8 prep init1");
      host_wr(A_STS0, 32'h7FFF_FFFF, "R8 prep clr0");
      check("R8 irq low before", {31'h0, irq}, 32'h0);
      doorbell(32'd1, 4'hF, "R8 not masked", 1'b0);
      read_all("R8");
      host_rd(A_EN0, "R8 en0 zero");

      // R11: unmapped offsets
      host_wr(8'h10, 32'hDEAD_BEEF, "R11 wr hole");
      host_rd(8'h10, "R11 hole");
      host_rd(8'h00, "R11 zero off");
      host_rd(8'hF0, "R11 high off");
      host_rd(8'hE9, "R11 unaligned");
      read_all("R11 unchanged");

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R11: %0d reads unanswered, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run hung, actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule